// File: doc/BRIEF.md
# Top-k Trap and Recirculation Marker

This stage sits between a destination sorter and the routing planes of a multi-plane cell switch. It receives a whole column of cell headers at once, already ordered by destination ascending and, within one destination, by priority descending. For every destination it lets at most k cells through to the routing planes and marks every further valid cell for recirculation. It also assigns each selected cell to a routing plane.

A cell that is marked for recirculation leaves with its two header halves exchanged, so that a later concentration sort orders it by priority. A second lane in the same block handles a cell that returns from the recirculation loop. It puts the halves back in their normal order and raises the switch-priority count by one, stopping at the largest value. All results are registered.

Header layout, most significant bit first: activity bit (1 means a valid cell), destination address of log2(N) bits, QoS indicator, switch-priority count. The first two fields form the routing half and the last two form the priority half. A larger priority value ranks higher. Position 0 of the column is the top of the sorted list.

Top module: `trap_marker`

## Requirements
- R1: A valid cell that is not trapped is flagged in `out_route`, is not flagged in `out_recirc`, and keeps its header unchanged.
- R2: A valid cell at position i ≥ k is trapped (flagged in `out_recirc`, not in `out_route`) exactly when the cell at position i−k is valid and has the same destination address.
- R3: Cells at positions 0 to k−1 are never trapped.
- R4: A cell whose activity bit is 0 is neither routed nor trapped, and its header passes unchanged. An invalid cell k positions above never causes a trap.
- R5: A trapped cell leaves with the layout {QoS, switch priority, activity bit, destination}, with the destination in the least significant bits.
- R6: Each routed cell gets plane number r mod k, where r is the count of routed cells at lower positions. Non-routed positions carry plane 0.
- R7: Column results appear one clock after `in_valid`. `out_valid` follows `in_valid` with the same one-cycle delay, and `out_route` and `out_recirc` are all zero while `out_valid` is low.
- R8: The return lane turns a swapped header back into {activity, destination, QoS, switch priority + 1}.
- R9: A switch-priority count already at its maximum stays at its maximum in the return lane.
- R10: `ret_out_valid` and `ret_out_hdr` follow `ret_valid` and `ret_hdr` one clock later.
- R11: While reset is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Column of headers present |
| in_hdr | input | N*HW | Sorted headers, position i in bits [i*HW +: HW] |
| out_valid | output | 1 | Column results present |
| out_hdr | output | N*HW | Headers, swapped where trapped |
| out_route | output | N | Per position: selected for a routing plane |
| out_recirc | output | N | Per position: marked for recirculation |
| out_plane | output | N*PW | Per position: routing plane number |
| ret_valid | input | 1 | Returning recirculated cell present |
| ret_hdr | input | HW | Returning header in swapped layout |
| ret_out_valid | output | 1 | Restored cell present |
| ret_out_hdr | output | HW | Restored header with raised switch priority |

## Verification
The column flags, the plane numbers, the rewritten headers and the restored return header each come from exactly one register stage. Each of them is due on the clock edge that follows the edge where its input was taken. The driver applies a stimulus on a falling edge and queues the expected result. The monitor then pops and compares that entry on the next falling edge where the matching valid output is high, so every comparison falls half a cycle after the register update that produced it. A result that comes early, comes late, or is missing shows up as a queue mismatch, an unexpected valid, or entries left in the queue at the end.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int unsigned DEF_PORTS  = 8;
   localparam int unsigned DEF_PLANES = 2;
   localparam int unsigned DEF_QOS_W  = 2;
   localparam int unsigned DEF_SP_W   = 3;

   typedef enum logic [0:0] {
      VERDICT_ROUTE  = 1'b0,
      VERDICT_RECIRC = 1'b1
   } verdict_e;
endpackage

// File: rtl/trap_compare.sv
module trap_compare #(
   parameter int unsigned N_PORTS = 8,
   parameter int unsigned K_DIST  = 2,
   parameter int unsigned DA_W    = 3
) (
   input  logic [N_PORTS-1:0]      act,
   input  logic [N_PORTS*DA_W-1:0] dest,
   output logic [N_PORTS-1:0]      trap
);
   for (genvar i = 0; i < N_PORTS; i++) begin : g_pos
      if (i < K_DIST) begin : g_head
         assign trap[i] = 1'b0;
      end else begin : g_cmp
         assign trap[i] = act[i] & act[i-K_DIST] &
                          (dest[i*DA_W +: DA_W] == dest[(i-K_DIST)*DA_W +: DA_W]);
      end
   end
endmodule

// File: rtl/plane_assign.sv
module plane_assign #(
   parameter int unsigned N_PORTS = 8,
   parameter int unsigned K_PLANES = 2,
   parameter int unsigned PW = 1
) (
   input  logic [N_PORTS-1:0]    route,
   output logic [N_PORTS*PW-1:0] plane
);
   logic [PW-1:0] rank;

   always_comb begin
      rank  = '0;
      plane = '0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (route[i]) begin
            plane[i*PW +: PW] = rank;
            if (rank == PW'(K_PLANES-1)) rank = '0;
            else                         rank = rank + 1'b1;
         end
      end
   end
endmodule

// File: rtl/field_swap.sv
module field_swap #(
   parameter int unsigned RW  = 4,
   parameter int unsigned PRW = 5,
   localparam int unsigned HW = RW + PRW
) (
   input  logic          swap_en,
   input  logic [HW-1:0] hdr_in,
   output logic [HW-1:0] hdr_out
);
   logic [RW-1:0]  route_half;
   logic [PRW-1:0] prio_half;

   assign route_half = hdr_in[HW-1 -: RW];
   assign prio_half  = hdr_in[PRW-1:0];
   assign hdr_out    = swap_en ? {prio_half, route_half} : hdr_in;
endmodule

// File: rtl/recirc_restore.sv
module recirc_restore #(
   parameter int unsigned RW    = 4,
   parameter int unsigned QOS_W = 2,
   parameter int unsigned SP_W  = 3,
   localparam int unsigned PRW  = QOS_W + SP_W,
   localparam int unsigned HW   = RW + PRW
) (
   input  logic [HW-1:0] swapped,
   output logic [HW-1:0] restored
);
   logic [RW-1:0]    route_half;
   logic [QOS_W-1:0] qos;
   logic [SP_W-1:0]  sp, sp_next;

   assign qos        = swapped[HW-1 -: QOS_W];
   assign sp         = swapped[RW +: SP_W];
   assign route_half = swapped[RW-1:0];
   assign sp_next    = (&sp) ? sp : sp + 1'b1;
   assign restored   = {route_half, qos, sp_next};
endmodule

// File: rtl/trap_marker.sv
module trap_marker #(
   parameter int unsigned N_PORTS  = trap_pkg::DEF_PORTS,
   parameter int unsigned K_PLANES = trap_pkg::DEF_PLANES,
   parameter int unsigned QOS_W    = trap_pkg::DEF_QOS_W,
   parameter int unsigned SP_W     = trap_pkg::DEF_SP_W,
   localparam int unsigned DA_W    = $clog2(N_PORTS),
   localparam int unsigned RW      = 1 + DA_W,
   localparam int unsigned PRW     = QOS_W + SP_W,
   localparam int unsigned HW      = RW + PRW,
   localparam int unsigned PW      = (K_PLANES > 1) ? $clog2(K_PLANES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [N_PORTS*HW-1:0]   in_hdr,
   output logic                    out_valid,
   output logic [N_PORTS*HW-1:0]   out_hdr,
   output logic [N_PORTS-1:0]      out_route,
   output logic [N_PORTS-1:0]      out_recirc,
   output logic [N_PORTS*PW-1:0]   out_plane,
   input  logic                    ret_valid,
   input  logic [HW-1:0]           ret_hdr,
   output logic                    ret_out_valid,
   output logic [HW-1:0]           ret_out_hdr
);
   import trap_pkg::*;

   initial begin
      assert (N_PORTS >= 2) else $error("N_PORTS must be at least 2");
      assert (K_PLANES >= 1 && K_PLANES <= N_PORTS) else $error("K_PLANES out of range");
      assert (QOS_W >= 1 && SP_W >= 1) else $error("priority fields need width");
   end

   logic [N_PORTS-1:0]      act;
   logic [N_PORTS*DA_W-1:0] dest;
   logic [N_PORTS-1:0]      trap;
   logic [N_PORTS-1:0]      route_c;
   logic [N_PORTS*HW-1:0]   hdr_c;
   logic [N_PORTS*PW-1:0]   plane_c;
   logic [HW-1:0]           restored_c;

   for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
      verdict_e verdict;
      assign act[i]                = in_hdr[i*HW + HW - 1];
      assign dest[i*DA_W +: DA_W]  = in_hdr[i*HW + PRW +: DA_W];
      assign verdict               = trap[i] ? VERDICT_RECIRC : VERDICT_ROUTE;
      assign route_c[i]            = act[i] & (verdict == VERDICT_ROUTE);

      field_swap #(.RW(RW), .PRW(PRW)) u_swap (
         .swap_en (verdict == VERDICT_RECIRC),
         .hdr_in  (in_hdr[i*HW +: HW]),
         .hdr_out (hdr_c[i*HW +: HW])
      );
   end

   trap_compare #(.N_PORTS(N_PORTS), .K_DIST(K_PLANES), .DA_W(DA_W)) u_trap (
      .act  (act),
      .dest (dest),
      .trap (trap)
   );

   plane_assign #(.N_PORTS(N_PORTS), .K_PLANES(K_PLANES), .PW(PW)) u_plane (
      .route (route_c),
      .plane (plane_c)
   );

   recirc_restore #(.RW(RW), .QOS_W(QOS_W), .SP_W(SP_W)) u_restore (
      .swapped  (ret_hdr),
      .restored (restored_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_hdr    <= '0;
         out_route  <= '0;
         out_recirc <= '0;
         out_plane  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_hdr    <= hdr_c;
            out_route  <= route_c;
            out_recirc <= trap;
            out_plane  <= plane_c;
         end else begin
            out_route  <= '0;
            out_recirc <= '0;
            out_plane  <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_out_valid <= 1'b0;
         ret_out_hdr   <= '0;
      end else begin
         ret_out_valid <= ret_valid;
         if (ret_valid) ret_out_hdr <= restored_c;
      end
   end
endmodule

// File: rtl/trap_marker_chk.sv
module trap_marker_chk #(
   parameter int unsigned N_PORTS  = 8,
   parameter int unsigned K_PLANES = 2,
   parameter int unsigned QOS_W    = 2,
   parameter int unsigned SP_W     = 3,
   localparam int unsigned DA_W    = $clog2(N_PORTS),
   localparam int unsigned RW      = 1 + DA_W,
   localparam int unsigned PRW     = QOS_W + SP_W,
   localparam int unsigned HW      = RW + PRW,
   localparam int unsigned PW      = (K_PLANES > 1) ? $clog2(K_PLANES) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [N_PORTS*HW-1:0] in_hdr,
   input logic                  out_valid,
   input logic [N_PORTS*HW-1:0] out_hdr,
   input logic [N_PORTS-1:0]    out_route,
   input logic [N_PORTS-1:0]    out_recirc,
   input logic [N_PORTS*PW-1:0] out_plane,
   input logic                  ret_valid,
   input logic [HW-1:0]         ret_hdr,
   input logic                  ret_out_valid,
   input logic [HW-1:0]         ret_out_hdr
);
   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_idle_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_route == '0 && out_recirc == '0));
   assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_route & out_recirc) == '0);
   assert_head_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_recirc[K_PLANES-1:0] == '0);
   assert_ret_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> ret_out_valid);
   assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && (&ret_hdr[RW +: SP_W])) |=> (&ret_out_hdr[SP_W-1:0]));

   for (genvar i = 0; i < N_PORTS; i++) begin : g_pos
      assert_route_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_route[i] |-> out_hdr[i*HW + HW - 1]);
      assert_recirc_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_recirc[i] |-> out_hdr[i*HW + DA_W]);
   end
endmodule

bind trap_marker trap_marker_chk #(
   .N_PORTS(N_PORTS), .K_PLANES(K_PLANES), .QOS_W(QOS_W), .SP_W(SP_W)
) u_chk (.*);

// File: tb/trap_marker_test.sv
`timescale 1ns/1ps
module trap_marker_test;
   localparam int N = 8;
   localparam int K = 2;
   localparam int HW = 9;
   localparam int PW = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [N*HW-1:0]   in_hdr = '0;
   logic              out_valid;
   logic [N*HW-1:0]   out_hdr;
   logic [N-1:0]      out_route, out_recirc;
   logic [N*PW-1:0]   out_plane;
   logic              ret_valid = 1'b0;
   logic [HW-1:0]     ret_hdr = '0;
   logic              ret_out_valid;
   logic [HW-1:0]     ret_out_hdr;

   always #2.5 clk = ~clk;

   trap_marker uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
      .out_valid(out_valid), .out_hdr(out_hdr), .out_route(out_route),
      .out_recirc(out_recirc), .out_plane(out_plane), .ret_valid(ret_valid),
      .ret_hdr(ret_hdr), .ret_out_valid(ret_out_valid), .ret_out_hdr(ret_out_hdr)
   );

   typedef struct {
      logic [N*HW-1:0] hdr;
      logic [N-1:0]    route;
      logic [N-1:0]    recirc;
      logic [N*PW-1:0] plane;
   } exp_t;

   exp_t          col_q[$];
   logic [HW-1:0] ret_q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] actual, input logic [127:0] expected);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
      end
   endtask

   function automatic logic [HW-1:0] mk(input int a, input int d, input int q, input int s);
      return {1'(a), 3'(d), 2'(q), 3'(s)};
   endfunction

   function automatic logic [HW-1:0] swp(input logic [HW-1:0] c);
      return {c[4:0], c[8:5]};
   endfunction

   // Expected column result, built from R1..R6.
   function automatic exp_t model(input logic [N*HW-1:0] h);
      exp_t e;
      int r = 0;
      e.hdr = '0; e.route = '0; e.recirc = '0; e.plane = '0;
      for (int i = 0; i < N; i++) begin
         logic [HW-1:0] c, u;
         bit tr;
         c = h[i*HW +: HW];
         tr = 1'b0;
         if (i >= K) begin
            u = h[(i-K)*HW +: HW];
            tr = c[8] && u[8] && (c[7:5] == u[7:5]);
         end
         e.recirc[i] = tr;
         e.route[i]  = c[8] && !tr;
         e.hdr[i*HW +: HW] = tr ? swp(c) : c;
         if (e.route[i]) begin
            e.plane[i*PW +: PW] = PW'(r % K);
            r++;
         end
      end
      return e;
   endfunction

   task automatic send_col(input logic [N*HW-1:0] h);
      @(negedge clk);
      in_valid = 1'b1;
      in_hdr = h;
      col_q.push_back(model(h));
   endtask

   task automatic send_ret(input logic [HW-1:0] s);
      logic [2:0] sp;
      @(negedge clk);
      ret_valid = 1'b1;
      ret_hdr = s;
      sp = s[6:4];
      ret_q.push_back({s[3:0], s[8:7], (sp == 3'd7) ? sp : 3'(sp + 1)});
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      ret_valid = 1'b0;
   endtask

   // Monitor: compares against the queue one cycle after each stimulus.
   always @(negedge clk) begin
      if (started && rst_n) begin
         if (out_valid) begin
            if (col_q.size() == 0) begin
               check(1'b0, "R7 unexpected out_valid", 128'(out_valid), 128'(0));
            end else begin
               exp_t e;
               e = col_q.pop_front();
               check(out_hdr == e.hdr, "R1/R4/R5 header", 128'(out_hdr), 128'(e.hdr));
               check(out_route == e.route, "R1/R2 route flags", 128'(out_route), 128'(e.route));
               check(out_recirc == e.recirc, "R2/R3 recirc flags", 128'(out_recirc), 128'(e.recirc));
               check(out_plane == e.plane, "R6 plane", 128'(out_plane), 128'(e.plane));
            end
         end else begin
            check(out_route == '0 && out_recirc == '0, "R7 idle flags",
                  128'({out_route, out_recirc}), 128'(0));
         end
         if (ret_out_valid) begin
            if (ret_q.size() == 0) begin
               check(1'b0, "R10 unexpected ret_out_valid", 128'(1), 128'(0));
            end else begin
               logic [HW-1:0] x;
               x = ret_q.pop_front();
               check(ret_out_hdr == x, "R8/R9 restored header", 128'(ret_out_hdr), 128'(x));
            end
         end
      end
   end

   function automatic logic [N*HW-1:0] rand_sorted();
      logic [HW-1:0] c [N];
      logic [N*HW-1:0] h;
      for (int i = 0; i < N; i++) begin
         c[i] = mk(($urandom % 5) != 0, $urandom % 4, $urandom % 4, $urandom % 8);
      end
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N - 1 - a; b++) begin
            logic [HW-1:0] t;
            if ({c[b][8:5], ~c[b][4:0]} > {c[b+1][8:5], ~c[b+1][4:0]}) begin
               t = c[b]; c[b] = c[b+1]; c[b+1] = t;
            end
         end
      end
      h = '0;
      for (int i = 0; i < N; i++) h[i*HW +: HW] = c[i];
      return h;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R7 actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [N*HW-1:0] h;
      void'($urandom(32'd7));
      // R11: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 0 && out_hdr == '0 && out_route == '0 && out_recirc == '0 &&
            out_plane == '0 && ret_out_valid == 0 && ret_out_hdr == '0,
            "R11 reset outputs", 128'(out_hdr), 128'(0));
      rst_n = 1'b1;
      started = 1'b1;
      idle();

      // R4: empty column
      send_col('0);
      // R1/R6: all destinations distinct
      h = '0;
      for (int i = 0; i < N; i++) h[i*HW +: HW] = mk(1, i, 1, 0);
      send_col(h);
      // R2/R3: three to one output, neighbours to the same output below
      h = {mk(1,7,0,1), mk(1,7,2,0), mk(1,6,0,0), mk(1,5,1,1),
           mk(1,4,0,0), mk(1,3,1,0), mk(1,3,2,0), mk(1,3,3,0)};
      send_col(h);
      idle();   // R7: gap cycle
      // R2/R5: five to one output, three to another
      h = {mk(1,5,0,0), mk(1,5,1,0), mk(1,5,2,2), mk(1,2,0,0),
           mk(1,2,0,3), mk(1,2,1,0), mk(1,2,3,1), mk(1,2,3,7)};
      send_col(h);
      // R4: invalid cells above with matching destination bits
      h = {mk(1,2,0,0), mk(1,2,1,0), mk(1,1,0,0), mk(1,1,1,0),
           mk(1,1,2,0), mk(0,1,0,0), mk(0,1,0,0), mk(0,1,0,0)};
      send_col(h);
      // R2/R6: all cells to one output
      h = '0;
      for (int i = 0; i < N; i++) h[i*HW +: HW] = mk(1, 7, 3 - i/2, 7 - i);
      send_col(h);
      for (int v = 0; v < 20; v++) send_col(rand_sorted());
      idle();

      // R8/R9/R10: return lane
      send_ret(swp(mk(1, 3, 2, 7)));   // R9 saturation
      send_ret(swp(mk(1, 6, 1, 0)));
      send_ret(swp(mk(1, 0, 3, 3)));
      idle();
      for (int v = 0; v < 6; v++) send_ret(swp(mk(1, $urandom % 8, $urandom % 4, $urandom % 8)));
      idle();

      repeat (4) @(negedge clk);
      check(col_q.size() == 0, "R7 column results outstanding", 128'(col_q.size()), 128'(0));
      check(ret_q.size() == 0, "R10 return results outstanding", 128'(ret_q.size()), 128'(0));
      done = 1'b1;
      finish_run();
   end
endmodule